// File: doc/BRIEF.md
# Feed-Gated PLL Register Controller

This block holds the software-visible settings of a clock-multiplier PLL and sits on a simple single-cycle memory-mapped bus. Software programs a control word (enable and clock connect) and a configuration word (multiplier M and divider P). These writes land only in pending copies. The PLL outputs stay as they are until software performs an unlock sequence on a dedicated feed register. That sequence copies every pending field into the active registers in one clock edge.

A read-only status word reports what the PLL is actually running with: the committed enable, connect, M and P, plus a lock flag. The lock flag is the PLL's lock input after a two-flip-flop synchroniser. Software is expected to enable the PLL, feed, wait for lock, set connect, and feed again. The hardware itself never checks lock before applying a committed connect, and it never drops connect when lock is lost.

Top module: `pll_feed_ctrl`

## Requirements
- R1: After reset, the enable, connect, multiplier and divider outputs are all zero. The pending copies and the read data are also zero.
- R2: A write to control (word address 0) or configuration (word address 1) changes only the pending copy. The PLL outputs hold until a commit. A read of either address returns its pending value: control bit 0 is enable and bit 1 is connect; configuration bits 4:0 are M and bits 6:5 are P.
- R3: A write of 0x00AA to the feed register (word address 3), followed by a write of 0x0055 to it, commits the pending values. The commit happens on the clock edge that accepts the 0x0055 write. All four active fields change on that same edge.
- R4: Any read or write to another address between the two feed writes aborts the sequence, so the following 0x0055 commits nothing. Cycles with no bus access do not abort it.
- R5: A feed write of any value other than 0x00AA or 0x0055 aborts the sequence. A repeated 0x00AA leaves the sequence armed, and a 0x0055 written while not armed commits nothing.
- R6: A read of status (word address 2) returns the committed values, not the pending ones. The layout is M in bits 4:0, P in bits 6:5, enable in bit 8, connect in bit 9 and lock in bit 10. All other bits are zero.
- R7: The lock bit in status follows the lock input delayed by two clock edges.
- R8: Bits outside the defined fields are ignored on write and read back as zero.
- R9: A committed connect drives the connect output whatever the lock state. Losing lock later does not clear connect.
- R10: Read data appears on the cycle after the read is accepted and holds until the next read. A read of the feed register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pll_lock_i | input | 1 | Lock indication from the PLL, asynchronous |
| pll_en_o | output | 1 | Committed PLL enable |
| pll_conn_o | output | 1 | Committed clock connect |
| pll_mul_o | output | 5 | Committed multiplier M |
| pll_div_o | output | 2 | Committed divider P |

## Verification
The unlock sequence is exercised with a clean back-to-back pair and with idle gaps between the two writes. These show that only real accesses break the sequence. Pairs interrupted by a read or a write elsewhere, a wrong feed value, a double 0x00AA and a stray 0x0055 each target a different arming or abort path. All-ones writes check the reserved bits. A lock pulse read out on consecutive cycles pins the synchroniser latency. Connect is committed with lock low, and lock is then dropped under a connected PLL, to show that lock gates nothing.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
    parameter int unsigned MUL_W  = 5;
    parameter int unsigned DIV_W  = 2;
    parameter int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(3);

    // status word bit positions for the single-bit fields
    localparam int unsigned ST_EN_BIT   = 8;
    localparam int unsigned ST_CONN_BIT = 9;
    localparam int unsigned ST_LOCK_BIT = 10;

    typedef struct packed {
        logic conn;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [MUL_W-1:0] mul;
    } cfg_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned CFG_W  = $bits(cfg_t);

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_ARMED = 1'b1
    } feed_st_e;
endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
    import pll_feed_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter logic [DW-1:0] KEY_ARM  = DW'(16'h00AA),
    parameter logic [DW-1:0] KEY_FIRE = DW'(16'h0055)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_we,
    input  logic          acc_feed,
    input  logic [DW-1:0] acc_data,
    output logic          commit_o
);
    typedef struct packed {
        feed_st_e st;
    } seq_t;

    seq_t s_d, s_q;
    logic feed_wr;

    always_comb begin
        s_d      = s_q;
        feed_wr  = acc_valid && acc_we && acc_feed;
        commit_o = (s_q.st == FS_ARMED) && feed_wr && (acc_data == KEY_FIRE);
        if (acc_valid) begin
            // any accepted access re-decides the arm state; idle cycles hold it
            s_d.st = (feed_wr && (acc_data == KEY_ARM)) ? FS_ARMED : FS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: FS_IDLE};
        else        s_q <= s_d;
    end

    p_abort_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(acc_we && acc_feed)) |=> !commit_o);

    p_abort_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_wr && (acc_data != KEY_ARM)) |=> !commit_o);
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    output logic lock_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t y_d, y_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb y_d.chain = lock_in;
        end else begin : g_many
            always_comb y_d.chain = {y_q.chain[STAGES-2:0], lock_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign lock_o = y_q.chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            p_lock_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 1) && $past(rst_n, 2)) |-> (lock_o == $past(lock_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs
    import pll_feed_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctrl,
    input  logic  wr_cfg,
    input  ctrl_t wctrl,
    input  cfg_t  wcfg,
    input  logic  commit,
    output ctrl_t pend_ctrl,
    output cfg_t  pend_cfg,
    output ctrl_t act_ctrl,
    output cfg_t  act_cfg
);
    typedef struct packed {
        ctrl_t pc;
        cfg_t  pf;
        ctrl_t ac;
        cfg_t  af;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (wr_ctrl) b_d.pc = wctrl;
        if (wr_cfg)  b_d.pf = wcfg;
        if (commit) begin
            b_d.ac = b_q.pc;
            b_d.af = b_q.pf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign pend_ctrl = b_q.pc;
    assign pend_cfg  = b_q.pf;
    assign act_ctrl  = b_q.ac;
    assign act_cfg   = b_q.af;

    p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_ctrl) && $stable(act_cfg)));

    p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((act_ctrl == $past(pend_ctrl)) && (act_cfg == $past(pend_cfg))));
endmodule

// File: rtl/pll_feed_ctrl.sv
module pll_feed_ctrl
    import pll_feed_pkg::*;
#(
    parameter int unsigned DW          = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              pll_lock_i,
    output logic              pll_en_o,
    output logic              pll_conn_o,
    output logic [MUL_W-1:0]  pll_mul_o,
    output logic [DIV_W-1:0]  pll_div_o
);
    localparam logic [DW-1:0] KEY_ARM  = DW'(16'h00AA);
    localparam logic [DW-1:0] KEY_FIRE = DW'(16'h0055);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t   r_d, r_q;
    logic  wr_ctrl, wr_cfg, rd_acc, commit, lock_s;
    ctrl_t pend_ctrl, act_ctrl, wctrl;
    cfg_t  pend_cfg, act_cfg, wcfg;
    logic [DW-1:0] rd_word;

    always_comb begin
        wr_ctrl = bus_sel && bus_we && (bus_addr == A_CTRL);
        wr_cfg  = bus_sel && bus_we && (bus_addr == A_CFG);
        rd_acc  = bus_sel && !bus_we;
        wctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        wcfg    = cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    pll_feed_seq #(.DW(DW), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_sel),
        .acc_we    (bus_we),
        .acc_feed  (bus_addr == A_FEED),
        .acc_data  (bus_wdata),
        .commit_o  (commit)
    );

    pll_shadow_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_cfg    (wr_cfg),
        .wctrl     (wctrl),
        .wcfg      (wcfg),
        .commit    (commit),
        .pend_ctrl (pend_ctrl),
        .pend_cfg  (pend_cfg),
        .act_ctrl  (act_ctrl),
        .act_cfg   (act_cfg)
    );

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_in (pll_lock_i),
        .lock_o  (lock_s)
    );

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            A_CTRL: rd_word[CTRL_W-1:0] = pend_ctrl;
            A_CFG:  rd_word[CFG_W-1:0]  = pend_cfg;
            A_STAT: begin
                rd_word[CFG_W-1:0]  = act_cfg;
                rd_word[ST_EN_BIT]   = act_ctrl.en;
                rd_word[ST_CONN_BIT] = act_ctrl.conn;
                rd_word[ST_LOCK_BIT] = lock_s;
            end
            default: rd_word = '0;
        endcase
        r_d = r_q;
        if (rd_acc) r_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata  = r_q.rdata;
    assign pll_en_o   = act_ctrl.en;
    assign pll_conn_o = act_ctrl.conn;
    assign pll_mul_o  = act_cfg.mul;
    assign pll_div_o  = act_cfg.div;

    p_commit_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (bus_sel && bus_we && (bus_addr == A_FEED) && (bus_wdata == KEY_FIRE)));

    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr == A_CTRL)) |=> (bus_rdata[DW-1:CTRL_W] == '0));

    p_conn_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_conn_o && !commit) |=> pll_conn_o);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));
endmodule

// File: tb/sim_pll_feed_ctrl.sv
module sim_pll_feed_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pll_lock_i = 1'b0;
    logic        pll_en_o, pll_conn_o;
    logic [4:0]  pll_mul_o;
    logic [1:0]  pll_div_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_pc = 0, m_pf = 0, m_ac = 0, m_af = 0, m_rd = 0;
    bit m_armed = 0;
    bit lq[$] = '{0, 0};

    always #2 clk = ~clk;

    pll_feed_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_lock_i(pll_lock_i), .pll_en_o(pll_en_o), .pll_conn_o(pll_conn_o),
        .pll_mul_o(pll_mul_o), .pll_div_o(pll_div_o)
    );

    function automatic int ref_read(int a);
        case (a)
            0: return m_pc;
            1: return m_pf;
            2: return m_af | ((m_ac & 1) << 8) | (((m_ac >> 1) & 1) << 9) | (int'(lq[0]) << 10);
            default: return 0;
        endcase
    endfunction

    task automatic model_edge(bit sel, bit we, int a, int wd);
        bit fire;
        if (sel && !we) m_rd = ref_read(a);
        fire = m_armed && sel && we && a == 3 && wd == 'h55;
        if (sel) m_armed = we && a == 3 && wd == 'hAA;
        void'(lq.pop_front());
        lq.push_back(pll_lock_i);
        if (fire) begin m_ac = m_pc; m_af = m_pf; end
        if (sel && we && a == 0) m_pc = wd & 'h3;
        if (sel && we && a == 1) m_pf = wd & 'h7F;
    endtask

    task automatic check(string tag);
        int got, exp;
        got = {pll_div_o, pll_mul_o, pll_conn_o, pll_en_o, bus_rdata};
        exp = ((m_af >> 5) & 3) << 24 | (m_af & 31) << 19 | ((m_ac >> 1) & 1) << 18
              | (m_ac & 1) << 17 | (m_rd & 'hFFFF) << 1;
        exp = exp >> 1;
        got = {7'd0, pll_div_o, pll_mul_o, pll_conn_o, pll_en_o, bus_rdata};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: div/mul/conn/en/rdata got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(bit sel, bit we, int a, int wd, string tag);
        bus_sel = sel; bus_we = we; bus_addr = a[1:0]; bus_wdata = wd[15:0];
        @(posedge clk);
        model_edge(sel, we, a, wd);
        @(negedge clk);
        bus_sel = 1'b0;
        check(tag);
    endtask

    task automatic wr(int a, int wd, string tag); step(1, 1, a, wd, tag); endtask
    task automatic rd(int a, string tag);         step(1, 0, a, 0, tag);  endtask
    task automatic idle(string tag);              step(0, 0, 0, 0, tag);  endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");
        rd(0, "R1 pending ctrl zero");
        rd(2, "R1 status zero");

        // R2: pending only
        wr(0, 'h0001, "R2 ctrl write shadowed");
        wr(1, 'h0023, "R2 cfg write shadowed");
        rd(0, "R2 ctrl reads pending");
        rd(1, "R2 cfg reads pending");
        rd(2, "R6 status still old");

        // R3: clean commit
        wr(3, 'hAA, "R3 arm");
        wr(3, 'h55, "R3 commit edge");
        rd(2, "R6 status committed");

        // R4: idle gaps allowed, intervening access aborts
        wr(1, 'h0045, "R2 new cfg");
        wr(3, 'hAA, "R4 arm");
        idle("R4 idle gap");
        idle("R4 idle gap");
        wr(3, 'h55, "R4 commit after idle");
        wr(0, 'h0000, "R2 ctrl cleared pending");
        wr(3, 'hAA, "R4 arm");
        rd(1, "R4 intervening read");
        wr(3, 'h55, "R4 aborted by read");
        wr(3, 'hAA, "R4 arm");
        wr(1, 'h001F, "R4 intervening write");
        wr(3, 'h55, "R4 aborted by write");
        rd(2, "R4 status unchanged");

        // R5: value mismatches
        wr(3, 'hAA, "R5 arm");
        wr(3, 'h56, "R5 wrong value");
        wr(3, 'h55, "R5 no commit after wrong value");
        wr(3, 'h55, "R5 stray fire");
        wr(3, 'hAA, "R5 arm");
        wr(3, 'hAA, "R5 rearm");
        wr(3, 'h55, "R5 commit after double arm");
        wr(3, 'h1AA, "R5 wide value not a key");
        wr(3, 'h55, "R5 no commit");

        // R8: reserved bits
        wr(0, 'hFFFF, "R8 ctrl all ones");
        rd(0, "R8 ctrl reserved zero");
        wr(1, 'hFFFF, "R8 cfg all ones");
        rd(1, "R8 cfg reserved zero");
        wr(3, 'hAA, "R8 arm");
        wr(3, 'h55, "R8 commit all ones");
        rd(2, "R8 status reserved zero");

        // R7: lock latency
        pll_lock_i = 1'b1;
        rd(2, "R7 lock edge0");
        rd(2, "R7 lock edge1");
        rd(2, "R7 lock edge2");
        pll_lock_i = 1'b0;
        rd(2, "R7 lock drop0");
        rd(2, "R7 lock drop1");
        rd(2, "R7 lock drop2");

        // R9: connect independent of lock
        wr(0, 'h0001, "R9 disconnect pending");
        wr(3, 'hAA, "R9 arm");
        wr(3, 'h55, "R9 commit disconnect");
        wr(0, 'h0003, "R9 connect pending");
        wr(3, 'hAA, "R9 arm");
        wr(3, 'h55, "R9 connect without lock");
        pll_lock_i = 1'b1;
        idle("R9 locked");
        idle("R9 locked");
        pll_lock_i = 1'b0;
        idle("R9 lock lost");
        idle("R9 lock lost");
        rd(2, "R9 status connected unlocked");

        // R10: read timing and feed reads
        rd(0, "R10 read ctrl");
        wr(1, 'h0011, "R10 rdata holds on write");
        idle("R10 rdata holds idle");
        rd(3, "R10 feed reads zero");
        idle("R10 hold zero");

        finish_run();
    end
endmodule